// File: doc/BRIEF.md
# Word-Fed SPI Master with Per-Entry Byte Count

This block is the shift engine of a SPI master. Software writes configuration and data through a small write-only register port. Each data write lands in an external 32-bit transmit queue together with a byte count, and the count is chosen by the address that was written. One queue entry can therefore put 1, 2, 3 or 4 bytes on the wire. The engine takes entries from that queue and shifts them out on MOSI while it samples MISO. For each entry it pushes one word into an external receive queue, with the received bytes packed at the bottom of that word. The queue storage lives outside the block. The block only sees a first-word-fall-through read side for transmit and a push side, with a full flag, for receive.

A control register holds the clock polarity and phase, a power-of-two clock divider, a master-mode bit, a manual-select bit and a four-line one-cold select field. A separate enable register gates all shifting. Shifting starts by itself whenever the engine is enabled and in master mode, an entry is waiting and the receive queue has room. Entries that follow one another run back to back with the slave kept selected.

Top module: `spi_word_master`

## Requirements
- R1: A write to byte address 0x1C pushes the write data with length code 3 (four bytes). Writes to 0x80, 0x84 and 0x88 push the write data with length codes 0, 1 and 2 (one, two and three bytes). The length code is the byte count minus one. A write to any other address pushes nothing.
- R2: The control register is at address 0x00. Its divider field is bits [5:3], with value v. While an entry shifts, one SCLK period lasts (2 << v) clock cycles. When no entry is shifting, SCLK rests at the polarity bit (control bit 1).
- R3: Control bit 2 is the phase. With phase 0, MOSI is valid at the first SCLK edge of each bit and MISO is sampled on that edge. With phase 1, MOSI is valid on the second edge of each bit and MISO is sampled on that edge. Both hold for either polarity.
- R4: An entry of N bytes produces exactly 8N sampling edges. Its bytes go out lowest byte first, and each byte goes out most significant bit first. Bytes of the entry above the lowest N are never transmitted.
- R5: Each entry produces exactly one receive push. The received bytes sit in the low N bytes of that word, placed by the same order as in R4, and the upper bytes are zero.
- R6: An entry is popped only while one is offered. It starts without further action once the engine is enabled, in master mode and the receive queue is not full. When the next entry is already waiting, it follows the previous one with the select lines held asserted throughout.
- R7: The select field is control bits [13:10], active low. When control bit 14 (manual) is set, the select lines equal the field at all times. When bit 14 is clear, the select lines equal the field while an entry shifts and are all ones otherwise.
- R8: Bit 0 of the register at 0x14 is the enable, and control bit 0 is master mode. While either is clear, no entry is popped. Clearing either one in the middle of an entry drops that entry at once: SCLK returns to its rest level, the lines deselect in automatic mode, and nothing is pushed to the receive queue.
- R9: While the receive queue reports full, no entry is popped. Shifting resumes once room appears.
- R10: After reset, all select lines are high, SCLK and MOSI are low, and there is no push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the write |
| reg_wdata | input | DATA_W | Write data |
| txq_push | output | 1 | Push into the transmit queue |
| txq_wdata | output | DATA_W | Word pushed into the transmit queue |
| txq_wlen | output | LEN_W | Byte count minus one of the pushed word |
| txq_valid | input | 1 | Transmit queue offers an entry |
| txq_rdata | input | DATA_W | Offered entry data |
| txq_rlen | input | LEN_W | Offered entry byte count minus one |
| txq_pop | output | 1 | Takes the offered entry |
| rxq_full | input | 1 | Receive queue has no room |
| rxq_push | output | 1 | Push into the receive queue |
| rxq_wdata | output | DATA_W | Received word, upper unused bytes zero |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | SS_W | Slave selects, active low |

## Verification
Some properties are checked on every cycle: the address-to-length decode of writes, the absence of pops while the queue is empty, the receive queue is full or the engine is disabled, and single-cycle receive pushes. The same cycle-by-cycle checks cover the select lines in manual mode and the rest level of SCLK while the lines are deselected. Bit order, byte packing, the SCLK period for a given divider and the edge used in each of the four modes can only be shown by the bench's scenarios. So can the held select across chained entries and the drop of an entry on disable. The bench records MOSI at the sampling edges and drives MISO from a known slave word.

// File: rtl/qsm_pkg.sv
// Package: shared constants for the word-fed SPI master.
// Assumes byte addressing, with the offsets below decoded on the full address.
package qsm_pkg;
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_EN   = 8'h14;
    localparam logic [7:0] OFF_TX4  = 8'h1C;
    localparam logic [7:0] OFF_TX1  = 8'h80;
    localparam logic [7:0] OFF_TX2  = 8'h84;
    localparam logic [7:0] OFF_TX3  = 8'h88;

    localparam int B_MASTER = 0;
    localparam int B_CPOL   = 1;
    localparam int B_CPHA   = 2;
    localparam int B_DIV    = 3;
    localparam int B_SS     = 10;
    localparam int B_MANUAL = 14;

    typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/qsm_regs.sv
// Module: qsm_regs
// Holds the control and enable registers and turns data writes into
// transmit-queue pushes, each tagged with a length code taken from the address.
// Assumes SS_W <= 4 and DIV_W <= 7, so the fields do not overlap.
module qsm_regs
    import qsm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SS_W   = 4,
    parameter int DIV_W  = 3,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cfg_master,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    output logic [DIV_W-1:0]  cfg_div,
    output logic [SS_W-1:0]   cfg_ss,
    output logic              cfg_manual,
    output logic              cfg_en,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic [LEN_W-1:0]  push_len
);
    // Control and enable registers: reset leaves every slave deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_master <= 1'b0;
            cfg_cpol   <= 1'b0;
            cfg_cpha   <= 1'b0;
            cfg_div    <= '0;
            cfg_ss     <= '1;
            cfg_manual <= 1'b0;
            cfg_en     <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_W'(OFF_CTRL)) begin
                cfg_master <= wdata[B_MASTER];
                cfg_cpol   <= wdata[B_CPOL];
                cfg_cpha   <= wdata[B_CPHA];
                cfg_div    <= wdata[B_DIV +: DIV_W];
                cfg_ss     <= wdata[B_SS +: SS_W];
                cfg_manual <= wdata[B_MANUAL];
            end
            if (addr == ADDR_W'(OFF_EN)) begin
                cfg_en <= wdata[0];
            end
        end
    end

    // Data-write decode: the address picks the byte count of the entry.
    always_comb begin
        push      = 1'b0;
        push_len  = '0;
        push_data = wdata;
        if (wr) begin
            if (addr == ADDR_W'(OFF_TX4)) begin
                push = 1'b1; push_len = LEN_W'(3);
            end else if (addr == ADDR_W'(OFF_TX1)) begin
                push = 1'b1; push_len = LEN_W'(0);
            end else if (addr == ADDR_W'(OFF_TX2)) begin
                push = 1'b1; push_len = LEN_W'(1);
            end else if (addr == ADDR_W'(OFF_TX3)) begin
                push = 1'b1; push_len = LEN_W'(2);
            end
        end
    end
endmodule

// File: rtl/qsm_clkdiv.sv
// Module: qsm_clkdiv
// Produces one tick at the end of each SCLK half period, which lasts (1 << div)
// clocks. It restarts from zero whenever run is low.
// Assumes div does not change while run is high.
module qsm_clkdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = ~({CNT_W{1'b1}} << div);
    assign tick  = run && (cnt == limit);

    // Half-period counter: it wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qsm_shifter.sv
// Module: qsm_shifter
// Serialises one queue entry at a time and collects the received bits.
// Bytes go lowest first and bits go MSB first, addressed as {byte, bit}.
// Each bit has two half periods. The sampling edge closes the first half.
// Assumes the receive full flag reflects a push within one clock.
module qsm_shifter
    import qsm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              txq_valid,
    input  logic [DATA_W-1:0] txq_rdata,
    input  logic [LEN_W-1:0]  txq_rlen,
    output logic              txq_pop,
    input  logic              rxq_full,
    output logic              rxq_push,
    output logic [DATA_W-1:0] rxq_wdata,
    input  logic              miso,
    output logic              mosi,
    output logic              sclk,
    output logic              busy
);
    localparam int POS_W = LEN_W + 3;

    eng_state_t         state;
    logic               half;
    logic [LEN_W-1:0]   byte_q;
    logic [2:0]         bit_q;
    logic [LEN_W-1:0]   last_byte_q;
    logic [DATA_W-1:0]  tx_q;
    logic [DATA_W-1:0]  rx_q;
    logic [DATA_W-1:0]  rx_next;
    logic               sclk_q;
    logic [POS_W-1:0]   pos;
    logic               last_bit;
    logic               end_a;
    logic               end_b;
    logic               can_start;
    logic               load;

    assign busy      = (state == ST_SHIFT);
    assign pos       = {byte_q, bit_q};
    assign last_bit  = (byte_q == last_byte_q) && (bit_q == 3'd0);
    assign end_a     = busy && tick && !half;
    assign end_b     = busy && tick && half;
    assign can_start = go && txq_valid && !rxq_full;
    assign load      = can_start && (!busy || (end_b && last_bit));

    assign txq_pop   = load;
    assign rxq_push  = go && end_a && last_bit;
    assign rxq_wdata = rx_next;
    assign mosi      = busy ? tx_q[pos] : 1'b0;
    assign sclk      = sclk_q;

    // Received word with the bit sampled at this edge merged in.
    always_comb begin
        rx_next      = rx_q;
        rx_next[pos] = miso;
    end

    // Entry sequencing: load, sample, advance, chain or drop to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            half        <= 1'b0;
            byte_q      <= '0;
            bit_q       <= 3'd7;
            last_byte_q <= '0;
            tx_q        <= '0;
            rx_q        <= '0;
            sclk_q      <= 1'b0;
        end else if (!go) begin
            state  <= ST_IDLE;
            half   <= 1'b0;
            sclk_q <= cpol;
        end else if (load) begin
            state       <= ST_SHIFT;
            half        <= 1'b0;
            byte_q      <= '0;
            bit_q       <= 3'd7;
            last_byte_q <= txq_rlen;
            tx_q        <= txq_rdata;
            rx_q        <= '0;
            sclk_q      <= cpol ^ cpha;
        end else if (busy) begin
            if (end_a) begin
                rx_q   <= rx_next;
                half   <= 1'b1;
                sclk_q <= ~(cpol ^ cpha);
            end else if (end_b) begin
                half <= 1'b0;
                if (last_bit) begin
                    state  <= ST_IDLE;
                    sclk_q <= cpol;
                end else begin
                    sclk_q <= cpol ^ cpha;
                    if (bit_q == 3'd0) begin
                        byte_q <= byte_q + 1'b1;
                        bit_q  <= 3'd7;
                    end else begin
                        bit_q <= bit_q - 1'b1;
                    end
                end
            end
        end else begin
            sclk_q <= cpol;
        end
    end
endmodule

// File: rtl/spi_word_master.sv
// Module: spi_word_master (top)
// Ties the register port, the half-period divider and the shift engine
// together, and drives the active-low selects in automatic or manual mode.
// Assumes the transmit queue offers first-word-fall-through data, and that a
// receive push is reflected in rxq_full on the next clock.
module spi_word_master #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int SS_W   = 4,
    parameter int DIV_W  = 3,
    localparam int LEN_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              txq_push,
    output logic [DATA_W-1:0] txq_wdata,
    output logic [LEN_W-1:0]  txq_wlen,
    input  logic              txq_valid,
    input  logic [DATA_W-1:0] txq_rdata,
    input  logic [LEN_W-1:0]  txq_rlen,
    output logic              txq_pop,
    input  logic              rxq_full,
    output logic              rxq_push,
    output logic [DATA_W-1:0] rxq_wdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [SS_W-1:0]   spi_ss_n
);
    logic             cfg_master;
    logic             cfg_cpol;
    logic             cfg_cpha;
    logic [DIV_W-1:0] cfg_div;
    logic [SS_W-1:0]  cfg_ss;
    logic             cfg_manual;
    logic             cfg_en;
    logic             cfg_go;
    logic             busy;
    logic             tick;

    assign cfg_go = cfg_en && cfg_master;

    qsm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SS_W(SS_W),
        .DIV_W(DIV_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_ss(cfg_ss), .cfg_manual(cfg_manual),
        .cfg_en(cfg_en), .push(txq_push), .push_data(txq_wdata), .push_len(txq_wlen)
    );

    qsm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick)
    );

    qsm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(cfg_go), .cpol(cfg_cpol), .cpha(cfg_cpha),
        .tick(tick), .txq_valid(txq_valid), .txq_rdata(txq_rdata),
        .txq_rlen(txq_rlen), .txq_pop(txq_pop), .rxq_full(rxq_full),
        .rxq_push(rxq_push), .rxq_wdata(rxq_wdata), .miso(spi_miso),
        .mosi(spi_mosi), .sclk(spi_sclk), .busy(busy)
    );

    // Select drive: the field itself in manual mode, otherwise only while shifting.
    always_comb begin
        if (cfg_manual || busy) spi_ss_n = cfg_ss;
        else                    spi_ss_n = '1;
    end
endmodule

// File: rtl/qsm_checker.sv
// Module: qsm_checker
// Cycle-by-cycle properties of the word-fed SPI master, bound into the top.
module qsm_checker
    import qsm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SS_W   = 4,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              txq_push,
    input logic [LEN_W-1:0]  txq_wlen,
    input logic              txq_valid,
    input logic              txq_pop,
    input logic              rxq_full,
    input logic              rxq_push,
    input logic              spi_sclk,
    input logic [SS_W-1:0]   spi_ss_n,
    input logic              cfg_manual,
    input logic [SS_W-1:0]   cfg_ss,
    input logic              cfg_cpol,
    input logic              cfg_go
);
    AST_TX_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_TX4)) |-> (txq_push && txq_wlen == LEN_W'(3))); // R1
    AST_NO_STRAY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |-> !txq_push); // R1
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_manual && (&spi_ss_n) && !(&cfg_ss) && $stable(cfg_cpol)) |-> (spi_sclk == cfg_cpol)); // R2
    AST_SINGLE_RX_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> !rxq_push); // R5
    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        txq_pop |-> txq_valid); // R6
    AST_MANUAL_SS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_manual |-> (spi_ss_n == cfg_ss)); // R7
    AST_DISABLED_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_go |-> !txq_pop); // R8
    AST_NO_POP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_full |-> !txq_pop); // R9
endmodule

bind spi_word_master qsm_checker #(.ADDR_W(ADDR_W), .SS_W(SS_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .txq_push(txq_push), .txq_wlen(txq_wlen), .txq_valid(txq_valid),
    .txq_pop(txq_pop), .rxq_full(rxq_full), .rxq_push(rxq_push),
    .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .cfg_manual(cfg_manual),
    .cfg_ss(cfg_ss), .cfg_cpol(cfg_cpol), .cfg_go(cfg_go)
);

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        txq_push, txq_pop, rxq_push, rxq_full, txq_valid;
    logic [31:0] txq_wdata, txq_rdata, rxq_wdata;
    logic [1:0]  txq_wlen, txq_rlen;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_ss_n;

    always #2.5 clk = ~clk;

    spi_word_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .txq_push(txq_push), .txq_wdata(txq_wdata),
        .txq_wlen(txq_wlen), .txq_valid(txq_valid), .txq_rdata(txq_rdata),
        .txq_rlen(txq_rlen), .txq_pop(txq_pop), .rxq_full(rxq_full),
        .rxq_push(rxq_push), .rxq_wdata(rxq_wdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
    );

    // Queue models around the block.
    logic [33:0] tx_mem [0:63];
    logic [31:0] rx_mem [0:63];
    logic [6:0]  tx_wp = '0, tx_rp = '0, rx_wp = '0;
    int          rx_lim = 100;

    assign txq_valid = (tx_wp != tx_rp);
    assign txq_rdata = tx_mem[tx_rp[5:0]][31:0];
    assign txq_rlen  = tx_mem[tx_rp[5:0]][33:32];
    assign rxq_full  = (int'(rx_wp) >= rx_lim);

    always @(posedge clk) begin
        if (txq_push) begin
            tx_mem[tx_wp[5:0]] <= {txq_wlen, txq_wdata};
            tx_wp <= tx_wp + 1'b1;
        end
        if (txq_pop) tx_rp <= tx_rp + 1'b1;
        if (rxq_push) begin
            rx_mem[rx_wp[5:0]] <= rxq_wdata;
            rx_wp <= rx_wp + 1'b1;
        end
    end

    // Slave model: records MOSI at sampling edges and serves MISO bits.
    logic mon_bits [0:511];
    int   mon_cyc  [0:511];
    logic sl_bits  [0:511];
    int   mon_n = 0;
    int   cyc = 0;
    logic prev_sclk = 1'b0;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0;

    assign spi_miso = sl_bits[mon_n];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_sclk <= spi_sclk;
        if (spi_sclk != prev_sclk && spi_ss_n != 4'hF &&
            spi_sclk == (cur_cpha ? cur_cpol : ~cur_cpol)) begin
            mon_bits[mon_n] <= spi_mosi;
            mon_cyc[mon_n]  <= cyc;
            mon_n <= mon_n + 1;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_ctrl(input bit m, input bit pol, input bit pha,
                                            input int dv, input logic [3:0] ss, input bit man);
        logic [31:0] w = '0;
        w[0] = m; w[1] = pol; w[2] = pha; w[5:3] = dv[2:0];
        w[13:10] = ss; w[14] = man;
        return w;
    endfunction

    task automatic set_mode(input bit pol, input bit pha);
        cur_cpol = pol; cur_cpha = pha;
    endtask

    // Wire position of frame bit k: byte k/8, bit 7 - k%8.
    task automatic load_slave(input int b, input logic [31:0] w, input int nb);
        for (int k = 0; k < 8 * nb; k++) sl_bits[b + k] = w[(k / 8) * 8 + 7 - (k % 8)];
    endtask

    function automatic logic [31:0] recon(input int b, input int nb);
        logic [31:0] w = '0;
        for (int k = 0; k < 8 * nb; k++) w[(k / 8) * 8 + 7 - (k % 8)] = mon_bits[b + k];
        return w;
    endfunction

    task automatic wait_rx(input int target);
        for (int i = 0; i < 20000 && int'(rx_wp) < target; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R10 ss_n", {28'd0, spi_ss_n}, 32'hF);
        chk("R10 sclk", {31'd0, spi_sclk}, 32'd0);
        chk("R10 mosi", {31'd0, spi_mosi}, 32'd0);
        chk("R10 pop/push", {30'd0, txq_pop, rxq_push}, 32'd0);
    endtask

    task automatic t_full_word();
        int b, ri, ti;
        set_mode(0, 0);
        wr(8'h00, mk_ctrl(1, 0, 0, 0, 4'b1110, 0));
        wr(8'h14, 32'd1);
        idle(2);
        chk("R7 auto idle ss", {28'd0, spi_ss_n}, 32'hF);
        b = mon_n; ri = int'(rx_wp); ti = int'(tx_wp);
        load_slave(b, 32'h12345678, 4);
        wr(8'h1C, 32'hA55A3CC3);
        wait_rx(ri + 1);
        idle(10);
        chk("R1 len code 4B", {30'd0, tx_mem[ti][33:32]}, 32'd3);
        chk("R4 bit count 4B", mon_n - b, 32);
        chk("R4 mosi word", recon(b, 4), 32'hA55A3CC3);
        chk("R5 rx word", rx_mem[ri], 32'h12345678);
        chk("R2 period v0", mon_cyc[b + 1] - mon_cyc[b], 2);
        chk("R2 rest level", {31'd0, spi_sclk}, 32'd0);
        chk("R7 deselect after", {28'd0, spi_ss_n}, 32'hF);
    endtask

    task automatic t_partial_chain();
        int b, ri, ti, rp0, gaps;
        bit started;
        wr(8'h14, 32'd0);
        set_mode(1, 1);
        wr(8'h00, mk_ctrl(1, 1, 1, 2, 4'b1101, 0));
        b = mon_n; ri = int'(rx_wp); ti = int'(tx_wp); rp0 = int'(tx_rp);
        load_slave(b, 32'hCAFEF00D, 1);
        load_slave(b + 8, 32'h0BADC0DE, 2);
        load_slave(b + 24, 32'h13579BDF, 3);
        wr(8'h80, 32'hDEADBEEF);
        wr(8'h84, 32'h76543210);
        wr(8'h88, 32'h89ABCDEF);
        idle(20);
        chk("R8 no pop disabled", tx_rp, rp0);
        wr(8'h14, 32'd1);
        gaps = 0; started = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!started && spi_ss_n != 4'hF) started = 1'b1;
            if (int'(rx_wp) >= ri + 3) break;
            if (started && spi_ss_n != 4'b1101) gaps++;
        end
        idle(20);
        chk("R6 ss held across chain", gaps, 0);
        chk("R1 len codes", {26'd0, tx_mem[ti][33:32], tx_mem[ti + 1][33:32], tx_mem[ti + 2][33:32]}, 32'b00_01_10);
        chk("R4 bit count chain", mon_n - b, 48);
        chk("R4 mosi 1B", recon(b, 1), 32'hEF);
        chk("R4 mosi 2B", recon(b + 8, 2), 32'h3210);
        chk("R4 mosi 3B", recon(b + 24, 3), 32'hABCDEF);
        chk("R5 rx 1B", rx_mem[ri], 32'h0D);
        chk("R5 rx 2B", rx_mem[ri + 1], 32'hC0DE);
        chk("R5 rx 3B", rx_mem[ri + 2], 32'h579BDF);
        chk("R2 period v2", mon_cyc[b + 1] - mon_cyc[b], 8);
        chk("R2 rest level cpol1", {31'd0, spi_sclk}, 32'd1);
    endtask

    task automatic t_mode(input bit pol, input bit pha, input logic [31:0] txw, input logic [31:0] slw);
        int b, ri;
        set_mode(pol, pha);
        wr(8'h00, mk_ctrl(1, pol, pha, 1, 4'b0111, 0));
        idle(2);
        b = mon_n; ri = int'(rx_wp);
        load_slave(b, slw, 2);
        wr(8'h84, txw);
        wait_rx(ri + 1);
        idle(10);
        chk("R3 mosi edge", recon(b, 2), txw & 32'hFFFF);
        chk("R3 miso edge", rx_mem[ri], slw & 32'hFFFF);
        chk("R2 period v1", mon_cyc[b + 1] - mon_cyc[b], 4);
    endtask

    task automatic t_manual();
        set_mode(0, 0);
        wr(8'h00, mk_ctrl(1, 0, 0, 0, 4'b1011, 1));
        idle(2);
        chk("R7 manual ss", {28'd0, spi_ss_n}, 32'hB);
        wr(8'h00, mk_ctrl(1, 0, 0, 0, 4'b0111, 1));
        idle(2);
        chk("R7 manual ss change", {28'd0, spi_ss_n}, 32'h7);
        wr(8'h00, mk_ctrl(1, 0, 0, 0, 4'b0111, 0));
        idle(2);
        chk("R7 auto deselect", {28'd0, spi_ss_n}, 32'hF);
    endtask

    task automatic t_abort();
        int ri, rp0;
        set_mode(0, 0);
        wr(8'h00, mk_ctrl(1, 0, 0, 3, 4'b1110, 0));
        ri = int'(rx_wp);
        wr(8'h1C, 32'h0F0F0F0F);
        idle(40);
        chk("R6 auto start", {28'd0, spi_ss_n}, 32'hE);
        wr(8'h14, 32'd0);
        idle(2);
        chk("R8 abort sclk", {31'd0, spi_sclk}, 32'd0);
        chk("R8 abort deselect", {28'd0, spi_ss_n}, 32'hF);
        idle(300);
        chk("R8 abort no rx", rx_wp, ri);
        chk("R8 entry dropped", {31'd0, txq_valid}, 32'd0);
        wr(8'h00, mk_ctrl(0, 0, 0, 0, 4'b1110, 0));
        wr(8'h14, 32'd1);
        rp0 = int'(tx_rp);
        load_slave(mon_n, 32'h0, 1);
        wr(8'h80, 32'h5A);
        idle(50);
        chk("R8 no master no pop", tx_rp, rp0);
        wr(8'h00, mk_ctrl(1, 0, 0, 0, 4'b1110, 0));
        wait_rx(ri + 1);
        chk("R6 starts on master", rx_wp, ri + 1);
    endtask

    task automatic t_stall();
        int ri, rp0;
        idle(30);
        set_mode(0, 0);
        ri = int'(rx_wp); rp0 = int'(tx_rp);
        rx_lim = ri;
        load_slave(mon_n, 32'h00009966, 2);
        wr(8'h84, 32'h1234ABCD);
        idle(60);
        chk("R9 no pop when full", tx_rp, rp0);
        chk("R9 no shift when full", {28'd0, spi_ss_n}, 32'hF);
        rx_lim = 100;
        wait_rx(ri + 1);
        chk("R9 resumes", rx_mem[ri], 32'h9966);
    endtask

    task automatic t_ignored();
        int wp0;
        idle(30);
        wp0 = int'(tx_wp);
        wr(8'h40, 32'hFFFFFFFF);
        wr(8'h20, 32'h11111111);
        wr(8'h8C, 32'h22222222);
        idle(4);
        chk("R1 other addr no push", tx_wp, wp0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_full_word();
        t_partial_chain();
        t_mode(0, 1, 32'h00001E96, 32'h0000A5C3);
        t_mode(1, 0, 32'h0000C381, 32'h00003C7E);
        t_manual();
        t_abort();
        t_stall();
        t_ignored();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule